// File: doc/BRIEF.md
# YUV 4:2:2 Video Bus Adapter

This block sits between an external 4:2:2 video port and the internal pixel datapath of a chip. It runs on a single double-rate clock. A pixel-rate qualifier of selectable polarity marks the pixel edges. The port is either 16 bits wide or 8 bits wide, chosen by one configuration bit.

- In the wide mode, luma travels on its own byte lane and the two chroma components alternate on a second lane.
- In the narrow mode, every sample shares one lane in the interleaved order Cb, Y, Cr, Y.

On the receive side, the adapter turns either format into one parallel word per pixel. The word holds a luma sample, one chroma sample, a marker telling Cb from Cr, and a valid flag. At the start of every active line the adapter realigns to a Cb sample, so the chroma order cannot drift.

On the transmit side, the adapter takes the same kind of parallel word and drives it back onto the wide or narrow bus. A limiter holds every outgoing sample to the nominal broadcast range unless full-scale output is enabled.

Top module: `vbus_adapter`

## Requirements
- R1: With `cfg_bus8`=0, each rising edge where the effective qualifier (`pix_qual` XOR `cfg_qual_inv`) is 1 and `line_act` is 1 captures `bus_y_i` and `bus_uv_i`. The cycle after that edge shows `rx_valid`=1 with `rx_y` equal to the captured Y lane and `rx_c` equal to the captured UV lane.
- R2: With `cfg_qual_inv`=1, the 16-bit path samples on edges where `pix_qual` is 0 and ignores edges where it is 1.
- R3: In 16-bit mode, the first pixel after `line_act` rises carries `rx_cr`=0 (Cb). Later pixels of the line alternate `rx_cr` between 1 and 0.
- R4: With `cfg_bus8`=1, every edge with `line_act`=1 takes one byte from `bus_y_i` in the order Cb, Y, Cr, Y. After each Y byte, one cycle shows `rx_valid`=1 with `rx_y`=that Y and `rx_c`=the chroma byte just before it. `rx_cr` is 0 after the first Y and 1 after the second. `rx_valid` is 0 after chroma bytes.
- R5: In 8-bit mode, one cycle with `line_act`=0 restarts the byte order, so the next active byte is treated as Cb.
- R6: An edge with `line_act`=0 produces no `rx_valid` in the following cycle.
- R7: In 16-bit mode, on each edge with effective qualifier 1, the transmit path registers the pixel.
  - If `tx_valid`=1, `bus_y_o`/`bus_uv_o` take the limited `tx_y`/`tx_c` and `bus_act_o`=1.
  - If `tx_valid`=0, they take blank values 16/128 and `bus_act_o`=0.
  - The outputs hold until the next qualifier edge.
- R8: In 8-bit mode, a qualifier edge puts the limited chroma on `bus_y_o` in the next cycle and the limited luma in the cycle after. `bus_uv_o` stays 128.
- R9: With `cfg_full_range`=0, outgoing samples are limited to 16..235 (below 16 becomes 16, above 235 becomes 235). With `cfg_full_range`=1, they pass unchanged over 0..255.
- R10: After synchronous reset, `rx_valid`=0, `bus_y_o`=16, `bus_uv_o`=128 and `bus_act_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate video clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus8 | input | 1 | 1: 8-bit interleaved bus, 0: 16-bit bus |
| cfg_qual_inv | input | 1 | Inverts the pixel qualifier |
| cfg_full_range | input | 1 | 1: disable output limiter |
| pix_qual | input | 1 | Pixel-rate qualifier |
| line_act | input | 1 | Active-line indication for receive |
| bus_y_i | input | 8 | Received Y lane (all samples in 8-bit mode) |
| bus_uv_i | input | 8 | Received chroma lane |
| rx_valid | output | 1 | Received pixel word valid |
| rx_y | output | 8 | Received luma |
| rx_c | output | 8 | Received chroma |
| rx_cr | output | 1 | 0: rx_c is Cb, 1: Cr |
| tx_valid | input | 1 | Transmit pixel present |
| tx_y | input | 8 | Transmit luma |
| tx_c | input | 8 | Transmit chroma |
| bus_y_o | output | 8 | Transmitted Y lane |
| bus_uv_o | output | 8 | Transmitted chroma lane |
| bus_act_o | output | 1 | Transmitted pixel is real data |

## Verification
Every receive result passes through one register, so a word appears exactly one cycle after its capture edge. In 8-bit mode that edge is the one carrying a Y byte. On transmit, a qualifier edge changes the outputs one cycle later. In 8-bit mode the luma byte follows one cycle after the chroma byte. The bench changes inputs 2 ns after a rising edge and reads outputs 2 ns after the next one, so each check sees the result of exactly one edge.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } byte_phase_t;
endpackage

// File: rtl/vbus_qual.sv
module vbus_qual (
  input  logic pix_qual,
  input  logic qual_inv,
  output logic q_en
);
  // Effective pixel edge marker: the qualifier level after optional inversion.
  assign q_en = pix_qual ^ qual_inv;
endmodule

// File: rtl/vbus_clamp.sv
module vbus_clamp #(
  parameter int DW = 8,
  parameter int LO = 16,
  parameter int HI = 235
) (
  input  logic          full_i,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam logic [DW-1:0] LO_V = LO[DW-1:0];
  localparam logic [DW-1:0] HI_V = HI[DW-1:0];

  always_comb begin
    if (full_i)          dout = din;
    else if (din < LO_V) dout = LO_V;
    else if (din > HI_V) dout = HI_V;
    else                 dout = din;
  end

  // R9: limited output stays inside the nominal band
  always_comb begin
    if (!full_i) begin
      a_r9_clamp_band: assert (dout >= LO_V && dout <= HI_V);
    end
  end
endmodule

// File: rtl/vbus_rx.sv
module vbus_rx
  import vbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus8,
  input  logic          q_en,
  input  logic          line_act,
  input  logic [DW-1:0] y_lane,
  input  logic [DW-1:0] uv_lane,
  output logic          rx_valid,
  output logic [DW-1:0] rx_y,
  output logic [DW-1:0] rx_c,
  output logic          rx_cr
);
  byte_phase_t   phase;
  logic          cr_next;
  logic [DW-1:0] c_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CB;
      cr_next  <= 1'b0;
      c_hold   <= '0;
      rx_valid <= 1'b0;
      rx_y     <= '0;
      rx_c     <= '0;
      rx_cr    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!line_act) begin
        phase   <= PH_CB;
        cr_next <= 1'b0;
      end else if (bus8) begin
        phase <= byte_phase_t'(phase + 2'd1);
        unique case (phase)
          PH_CB, PH_CR: c_hold <= y_lane;
          PH_Y0, PH_Y1: begin
            rx_valid <= 1'b1;
            rx_y     <= y_lane;
            rx_c     <= c_hold;
            rx_cr    <= (phase == PH_Y1);
          end
          default: ;
        endcase
      end else if (q_en) begin
        rx_valid <= 1'b1;
        rx_y     <= y_lane;
        rx_c     <= uv_lane;
        rx_cr    <= cr_next;
        cr_next  <= ~cr_next;
      end
    end
  end

  // R6: a word only follows an active edge
  a_r6_idle_no_word: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(line_act));
  // R4: in the narrow mode words never come on consecutive cycles
  a_r4_word_spacing: assert property (@(posedge clk) disable iff (rst)
    (bus8 && rx_valid) |=> (!rx_valid || !bus8));
  // R1: a wide-mode word follows a qualifier edge
  a_r1_wide_on_qual: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !bus8 && $past(!bus8)) |-> $past(q_en));
  // R10: nothing valid straight out of reset
  a_r10_rx_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rx_valid);
endmodule

// File: rtl/vbus_tx.sv
module vbus_tx #(
  parameter int DW = 8,
  parameter int LO = 16,
  parameter int HI = 235
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus8,
  input  logic          q_en,
  input  logic          full_range,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_y,
  input  logic [DW-1:0] tx_c,
  output logic [DW-1:0] bus_y_o,
  output logic [DW-1:0] bus_uv_o,
  output logic          bus_act_o
);
  localparam logic [DW-1:0] BLANK_Y = LO[DW-1:0];
  localparam logic [DW-1:0] BLANK_C = DW'(1) << (DW - 1);
  localparam int NLANE = 2;

  logic [DW-1:0] src  [NLANE];
  logic [DW-1:0] lim  [NLANE];
  logic [DW-1:0] y_hold;
  logic          second;

  assign src[0] = tx_valid ? tx_y : BLANK_Y;
  assign src[1] = tx_valid ? tx_c : BLANK_C;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    vbus_clamp #(.DW(DW), .LO(LO), .HI(HI)) u_clamp (
      .full_i (full_range),
      .din    (src[g]),
      .dout   (lim[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_y_o   <= BLANK_Y;
      bus_uv_o  <= BLANK_C;
      bus_act_o <= 1'b0;
      y_hold    <= BLANK_Y;
      second    <= 1'b0;
    end else if (q_en) begin
      bus_act_o <= tx_valid;
      if (bus8) begin
        bus_y_o  <= lim[1];
        bus_uv_o <= BLANK_C;
        y_hold   <= lim[0];
        second   <= 1'b1;
      end else begin
        bus_y_o  <= lim[0];
        bus_uv_o <= lim[1];
        second   <= 1'b0;
      end
    end else if (second) begin
      bus_y_o <= y_hold;
      second  <= 1'b0;
    end
  end

  // R7: chroma lane and activity flag only move on qualifier edges
  a_r7_uv_hold: assert property (@(posedge clk) disable iff (rst)
    !q_en |=> $stable(bus_uv_o));
  a_r7_act_hold: assert property (@(posedge clk) disable iff (rst)
    !q_en |=> $stable(bus_act_o));
  // R8: narrow mode keeps the chroma lane at mid level
  a_r8_uv_mid: assert property (@(posedge clk) disable iff (rst)
    (q_en && bus8) |=> (bus_uv_o == BLANK_C));
endmodule

// File: rtl/vbus_adapter.sv
module vbus_adapter #(
  parameter int DW = 8,
  parameter int LO = 16,
  parameter int HI = 235
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_bus8,
  input  logic          cfg_qual_inv,
  input  logic          cfg_full_range,
  input  logic          pix_qual,
  input  logic          line_act,
  input  logic [DW-1:0] bus_y_i,
  input  logic [DW-1:0] bus_uv_i,
  output logic          rx_valid,
  output logic [DW-1:0] rx_y,
  output logic [DW-1:0] rx_c,
  output logic          rx_cr,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_y,
  input  logic [DW-1:0] tx_c,
  output logic [DW-1:0] bus_y_o,
  output logic [DW-1:0] bus_uv_o,
  output logic          bus_act_o
);
  logic q_en;

  vbus_qual u_qual (
    .pix_qual (pix_qual),
    .qual_inv (cfg_qual_inv),
    .q_en     (q_en)
  );

  vbus_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .bus8     (cfg_bus8),
    .q_en     (q_en),
    .line_act (line_act),
    .y_lane   (bus_y_i),
    .uv_lane  (bus_uv_i),
    .rx_valid (rx_valid),
    .rx_y     (rx_y),
    .rx_c     (rx_c),
    .rx_cr    (rx_cr)
  );

  vbus_tx #(.DW(DW), .LO(LO), .HI(HI)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .bus8       (cfg_bus8),
    .q_en       (q_en),
    .full_range (cfg_full_range),
    .tx_valid   (tx_valid),
    .tx_y       (tx_y),
    .tx_c       (tx_c),
    .bus_y_o    (bus_y_o),
    .bus_uv_o   (bus_uv_o),
    .bus_act_o  (bus_act_o)
  );
endmodule

// File: tb/sim_vbus_adapter.sv
`timescale 1ns/1ps
module sim_vbus_adapter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_bus8 = 0, cfg_qual_inv = 0, cfg_full_range = 0;
  logic pix_qual = 0, line_act = 0;
  logic [7:0] bus_y_i = 0, bus_uv_i = 0;
  logic rx_valid, rx_cr;
  logic [7:0] rx_y, rx_c;
  logic tx_valid = 0;
  logic [7:0] tx_y = 0, tx_c = 0;
  logic [7:0] bus_y_o, bus_uv_o;
  logic bus_act_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  vbus_adapter u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic rx_step(input logic q, input logic act, input logic [7:0] y, input logic [7:0] uv);
    pix_qual = q; line_act = act; bus_y_i = y; bus_uv_i = uv;
    tick();
  endtask

  task automatic t_reset();
    chk("R10 rx_valid", rx_valid, 0);
    chk("R10 bus_y_o", bus_y_o, 16);
    chk("R10 bus_uv_o", bus_uv_o, 128);
    chk("R10 bus_act_o", bus_act_o, 0);
  endtask

  task automatic t_rx16();
    cfg_bus8 = 0; cfg_qual_inv = 0;
    rx_step(1, 0, 8'h00, 8'h00);
    chk("R6 inactive edge", rx_valid, 0);
    rx_step(1, 1, 8'h5A, 8'h33);
    chk("R1 valid", rx_valid, 1);
    chk("R1 y", rx_y, 8'h5A);
    chk("R1 c", rx_c, 8'h33);
    chk("R3 first is Cb", rx_cr, 0);
    rx_step(0, 1, 8'hEE, 8'hEE);
    chk("R1 off edge", rx_valid, 0);
    rx_step(1, 1, 8'h61, 8'hC4);
    chk("R3 second is Cr", rx_cr, 1);
    chk("R1 y2", rx_y, 8'h61);
    rx_step(0, 1, 8'h00, 8'h00);
    rx_step(1, 1, 8'h70, 8'h22);
    chk("R3 third is Cb", rx_cr, 0);
  endtask

  task automatic t_pol();
    cfg_bus8 = 0; cfg_qual_inv = 1;
    rx_step(1, 0, 8'h00, 8'h00);
    rx_step(0, 1, 8'h41, 8'h52);
    chk("R2 low qual samples", rx_valid, 1);
    chk("R2 y", rx_y, 8'h41);
    rx_step(1, 1, 8'h99, 8'h99);
    chk("R2 high qual ignored", rx_valid, 0);
    rx_step(0, 0, 8'h12, 8'h12);
    chk("R6 inactive no word", rx_valid, 0);
    cfg_qual_inv = 0;
  endtask

  task automatic t_rx8();
    cfg_bus8 = 1;
    rx_step(0, 0, 8'h00, 8'h00);
    rx_step(1, 1, 8'h40, 8'h00);
    chk("R4 after Cb no word", rx_valid, 0);
    rx_step(0, 1, 8'h50, 8'h00);
    chk("R4 word0 valid", rx_valid, 1);
    chk("R4 word0 y", rx_y, 8'h50);
    chk("R4 word0 c", rx_c, 8'h40);
    chk("R4 word0 Cb", rx_cr, 0);
    rx_step(1, 1, 8'h60, 8'h00);
    chk("R4 after Cr no word", rx_valid, 0);
    rx_step(0, 1, 8'h70, 8'h00);
    chk("R4 word1 y", rx_y, 8'h70);
    chk("R4 word1 c", rx_c, 8'h60);
    chk("R4 word1 Cr", rx_cr, 1);
  endtask

  task automatic t_realign();
    cfg_bus8 = 1;
    rx_step(1, 1, 8'h11, 8'h00);
    rx_step(0, 1, 8'h22, 8'h00);
    rx_step(1, 0, 8'h00, 8'h00);
    chk("R6 gap no word", rx_valid, 0);
    rx_step(0, 1, 8'h33, 8'h00);
    rx_step(1, 1, 8'h44, 8'h00);
    chk("R5 realigned word", rx_valid, 1);
    chk("R5 realigned Cb", rx_cr, 0);
    chk("R5 realigned c", rx_c, 8'h33);
    line_act = 0;
  endtask

  task automatic tx_step(input logic q, input logic v, input logic [7:0] y, input logic [7:0] c);
    pix_qual = q; tx_valid = v; tx_y = y; tx_c = c;
    tick();
  endtask

  task automatic t_tx16();
    cfg_bus8 = 0; cfg_full_range = 0;
    tx_step(1, 1, 8'h05, 8'hF0);
    chk("R9 y low limit", bus_y_o, 16);
    chk("R9 c high limit", bus_uv_o, 235);
    chk("R7 act", bus_act_o, 1);
    tx_step(0, 1, 8'h80, 8'h80);
    chk("R7 hold y", bus_y_o, 16);
    chk("R7 hold uv", bus_uv_o, 235);
    tx_step(1, 1, 8'h80, 8'h71);
    chk("R7 in-range y", bus_y_o, 8'h80);
    chk("R7 in-range uv", bus_uv_o, 8'h71);
    tx_step(1, 0, 8'hAA, 8'hAA);
    chk("R7 blank y", bus_y_o, 16);
    chk("R7 blank uv", bus_uv_o, 128);
    chk("R7 blank act", bus_act_o, 0);
    cfg_full_range = 1;
    tx_step(1, 1, 8'h05, 8'hF0);
    chk("R9 full y", bus_y_o, 8'h05);
    chk("R9 full uv", bus_uv_o, 8'hF0);
    cfg_full_range = 0;
  endtask

  task automatic t_tx8();
    cfg_bus8 = 1; cfg_full_range = 0;
    tx_step(1, 1, 8'h90, 8'h30);
    chk("R8 chroma first", bus_y_o, 8'h30);
    chk("R8 uv mid", bus_uv_o, 128);
    tx_step(0, 0, 8'h00, 8'h00);
    chk("R8 luma second", bus_y_o, 8'h90);
    tx_step(1, 1, 8'hFF, 8'h02);
    chk("R9 narrow chroma limit", bus_y_o, 16);
    tx_step(0, 0, 8'h00, 8'h00);
    chk("R9 narrow luma limit", bus_y_o, 235);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    t_reset();
    t_rx16();
    t_pol();
    t_rx8();
    t_realign();
    t_tx16();
    t_tx8();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule